// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting watchdog whose refresh is only legal inside a window near the end of the count. A 32-bit counter starts from a reload value and counts down by one on every cycle in which a tick-enable input is high, provided the watchdog is enabled. Software keeps the system alive by writing a 32-bit key to a refresh register. A refresh with the key reloads the counter. If the counter is still above a configured ceiling when that refresh arrives, the refresh counts as a fault. If the counter is allowed to run out, that is also a fault.

The reload value, the ceiling, the enable and the fault mode come in on configuration inputs. These stand for settings held in non-volatile storage. The reload value is built from a 26-bit field in the upper bits, and its six low bits are always one. A fault produces one of two actions. It either gives a one-cycle reset pulse, or it latches a raw timeout status bit that can raise an interrupt. The same fault can also latch a wakeup status bit while the system is asleep. Software reads everything through a small word-addressed register port. Raw status bits are cleared by writing one to them.

Top module: `wwdt_top`

## Requirements
- R1: The reload value is `{cfg_load, 6'b111111}`. While `rst_n` is low, the counter loads the reload value, the control enables and raw bits clear to 0, and all three outputs are 0. Register 0 reads the counter, register 1 reads the reload value and register 2 reads the ceiling.
- R2: The counter decreases by one on a clock edge only when `tick_en` and `cfg_enable` are both 1. Otherwise it holds its value, unless a refresh or expiry reloads it.
- R3: A write to register 3 refreshes the watchdog only when the data is exactly 0xAC15DE42. Any other data leaves the counter unchanged. Register 3 always reads 0.
- R4: A refresh made while the counter is at or below the ceiling reloads the counter on the next edge and raises no fault.
- R5: A refresh made while the watchdog is enabled and the counter is above the ceiling still reloads the counter, and it raises a fault on the same edge.
- R6: When the ceiling is at or above the reload value, a refresh raises no fault at any counter value.
- R7: A tick while the enabled counter is at 0 is an expiry. It raises a fault and reloads the counter.
- R8: With `cfg_mode` = 0, every fault drives `wd_reset_o` high for exactly one cycle, starting in the cycle after the fault edge. It does not change the raw status.
- R9: With `cfg_mode` = 1, a fault sets raw timeout (register 7 bit 0) and does not pulse `wd_reset_o`. `timeout_irq_o` equals raw timeout AND control bit 0.
- R10: Register 6 bit 0 reads 1 when the counter is at or below the ceiling, and 0 otherwise.
- R11: In register 7, writing 1 to a bit clears that bit and writing 0 leaves it unchanged. If a set and a clear happen on the same edge, the set wins.
- R12: A fault in mode 1 while `sleep_i` is 1 also sets raw wakeup (register 7 bit 1). `wakeup_irq_o` equals raw wakeup AND control bit 1.
- R13: Register 5 holds the timeout enable in bit 0 and the wakeup enable in bit 1; both are writable. Bit 2 reads `cfg_mode` and cannot be written. The other bits read 0. Register 4 bit 0 reads `cfg_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count-down strobe |
| cfg_load | input | 26 | Upper bits of the reload value |
| cfg_ceiling | input | 32 | Highest counter value at which a refresh is permitted |
| cfg_enable | input | 1 | Watchdog enable |
| cfg_mode | input | 1 | Fault action: 0 gives a reset pulse, 1 gives an interrupt |
| sleep_i | input | 1 | System is in a sleep state |
| bus_addr | input | 3 | Word index of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| wd_reset_o | output | 1 | One-cycle reset request |
| timeout_irq_o | output | 1 | Timeout interrupt |
| wakeup_irq_o | output | 1 | Wakeup interrupt |

## Verification
Refreshes are made at several counter positions:
- just above the ceiling,
- exactly on it,
- with the ceiling raised above the reload value.

This separates a correct comparison from a strict-versus-inclusive mistake, and it shows whether the window can be turned off. Key writes with wrong data and ticks with the enable low show whether the reload and decrement conditions are gated correctly. Expiries are run in both modes, with and without sleep. They show whether a fault is routed to the reset pulse or to the raw bits. Clear writes of 0 and 1 show whether each raw bit is cleared independently.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

  localparam int unsigned WD_CNT_W  = 32;
  localparam int unsigned WD_CFG_W  = 26;
  localparam int unsigned WD_ADDR_W = 3;

  typedef enum logic [WD_ADDR_W-1:0] {
    RA_COUNT  = 3'd0,
    RA_RELOAD = 3'd1,
    RA_CEIL   = 3'd2,
    RA_KEY    = 3'd3,
    RA_ENABLE = 3'd4,
    RA_CTRL   = 3'd5,
    RA_STAT   = 3'd6,
    RA_RAW    = 3'd7
  } wd_reg_e;

  typedef struct packed {
    logic wake_en;
    logic tmo_en;
  } wd_ctrl_t;

  typedef struct packed {
    logic wake;
    logic tmo;
  } wd_raw_t;

endpackage

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int unsigned CNT_W = WD_CNT_W,
  parameter int unsigned CFG_W = WD_CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cfg_enable,
  input  logic [CFG_W-1:0] cfg_load,
  input  logic [CNT_W-1:0] cfg_ceiling,
  input  logic             refresh_req,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             window_o,
  output logic             expiry_o,
  output logic             early_o
);

  localparam int unsigned FIX_W = CNT_W - CFG_W;

  function automatic logic [CNT_W-1:0] reload_of(input logic [CFG_W-1:0] f);
    return {f, {FIX_W{1'b1}}};
  endfunction

  function automatic logic inside_window(input logic [CNT_W-1:0] c,
                                         input logic [CNT_W-1:0] ceil);
    return c <= ceil;
  endfunction

  logic [CNT_W-1:0] count_q, count_d;
  logic             step;

  assign reload_o = reload_of(cfg_load);
  assign window_o = inside_window(count_q, cfg_ceiling);
  assign step     = tick_en & cfg_enable;
  assign expiry_o = step & (count_q == '0);
  assign early_o  = refresh_req & cfg_enable & ~window_o;

  always_comb begin
    count_d = count_q;
    if (refresh_req || expiry_o) count_d = reload_o;
    else if (step)               count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= reload_o;
    else        count_q <= count_d;
  end

  assign count_o = count_q;

endmodule

// File: rtl/wwdt_events.sv
module wwdt_events
  import wwdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fault,
  input  logic     cfg_mode,
  input  logic     sleep_i,
  input  wd_ctrl_t ctrl,
  input  wd_raw_t  clr,
  output wd_raw_t  raw_o,
  output logic     wd_reset_o,
  output logic     timeout_irq_o,
  output logic     wakeup_irq_o
);

  wd_raw_t raw_q, set_w;
  logic    rst_q;

  assign set_w.tmo  = fault & cfg_mode;
  assign set_w.wake = fault & cfg_mode & sleep_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      rst_q <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr) | set_w;
      rst_q <= fault & ~cfg_mode;
    end
  end

  assign raw_o         = raw_q;
  assign wd_reset_o    = rst_q;
  assign timeout_irq_o = raw_q.tmo & ctrl.tmo_en;
  assign wakeup_irq_o  = raw_q.wake & ctrl.wake_en;

endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter int unsigned     CNT_W = WD_CNT_W,
  parameter logic [CNT_W-1:0] KEY  = 32'hAC15DE42
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WD_ADDR_W-1:0] bus_addr,
  input  logic                 bus_we,
  input  logic [CNT_W-1:0]     bus_wdata,
  input  logic [CNT_W-1:0]     count,
  input  logic [CNT_W-1:0]     reload,
  input  logic [CNT_W-1:0]     ceiling,
  input  logic                 cfg_enable,
  input  logic                 cfg_mode,
  input  logic                 window,
  input  wd_raw_t              raw,
  output logic [CNT_W-1:0]     bus_rdata,
  output logic                 refresh_req,
  output wd_ctrl_t             ctrl_o,
  output wd_raw_t              clr_o
);

  wd_reg_e  sel;
  wd_ctrl_t ctrl_q;

  assign sel         = wd_reg_e'(bus_addr);
  assign refresh_req = bus_we && (sel == RA_KEY) && (bus_wdata == KEY);
  assign clr_o       = (bus_we && sel == RA_RAW) ? wd_raw_t'(bus_wdata[1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (bus_we && sel == RA_CTRL) ctrl_q <= wd_ctrl_t'(bus_wdata[1:0]);
  end

  assign ctrl_o = ctrl_q;

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RA_COUNT:  bus_rdata = count;
      RA_RELOAD: bus_rdata = reload;
      RA_CEIL:   bus_rdata = ceiling;
      RA_KEY:    bus_rdata = '0;
      RA_ENABLE: bus_rdata[0]   = cfg_enable;
      RA_CTRL:   bus_rdata[2:0] = {cfg_mode, ctrl_q};
      RA_STAT:   bus_rdata[0]   = window;
      RA_RAW:    bus_rdata[1:0] = raw;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int unsigned      CNT_W = WD_CNT_W,
  parameter int unsigned      CFG_W = WD_CFG_W,
  parameter logic [CNT_W-1:0] KEY   = 32'hAC15DE42
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [CFG_W-1:0]     cfg_load,
  input  logic [CNT_W-1:0]     cfg_ceiling,
  input  logic                 cfg_enable,
  input  logic                 cfg_mode,
  input  logic                 sleep_i,
  input  logic [WD_ADDR_W-1:0] bus_addr,
  input  logic                 bus_we,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  output logic                 wd_reset_o,
  output logic                 timeout_irq_o,
  output logic                 wakeup_irq_o
);

  // Named internal events, also observed by the bound checker
  logic [CNT_W-1:0] count_w, reload_w;
  logic             window_w, expiry_w, early_w, refresh_w, fault_w;
  wd_ctrl_t         ctrl_w;
  wd_raw_t          clr_w, raw_w;

  assign fault_w = expiry_w | early_w;

  wwdt_core #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cfg_enable  (cfg_enable),
    .cfg_load    (cfg_load),
    .cfg_ceiling (cfg_ceiling),
    .refresh_req (refresh_w),
    .count_o     (count_w),
    .reload_o    (reload_w),
    .window_o    (window_w),
    .expiry_o    (expiry_w),
    .early_o     (early_w)
  );

  wwdt_regs #(.CNT_W(CNT_W), .KEY(KEY)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .count       (count_w),
    .reload      (reload_w),
    .ceiling     (cfg_ceiling),
    .cfg_enable  (cfg_enable),
    .cfg_mode    (cfg_mode),
    .window      (window_w),
    .raw         (raw_w),
    .bus_rdata   (bus_rdata),
    .refresh_req (refresh_w),
    .ctrl_o      (ctrl_w),
    .clr_o       (clr_w)
  );

  wwdt_events u_events (
    .clk           (clk),
    .rst_n         (rst_n),
    .fault         (fault_w),
    .cfg_mode      (cfg_mode),
    .sleep_i       (sleep_i),
    .ctrl          (ctrl_w),
    .clr           (clr_w),
    .raw_o         (raw_w),
    .wd_reset_o    (wd_reset_o),
    .timeout_irq_o (timeout_irq_o),
    .wakeup_irq_o  (wakeup_irq_o)
  );

endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             cfg_enable,
  input logic             cfg_mode,
  input logic [CNT_W-1:0] cfg_ceiling,
  input logic [CNT_W-1:0] count_w,
  input logic [CNT_W-1:0] reload_w,
  input logic             refresh_w,
  input logic             fault_w,
  input logic             raw_tmo,
  input logic             wd_reset_o
);

  // R8
  reset_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset_o |=> !wd_reset_o);

  // R4
  refresh_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_w |=> count_w == $past(reload_w));

  // R5
  early_fault_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_w && cfg_enable && !cfg_mode && count_w > cfg_ceiling) |=> wd_reset_o);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_en && cfg_enable) && !refresh_w) |=> $stable(count_w));

  // R9
  raw_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_tmo) |-> $past(fault_w && cfg_mode));

  // R8
  reset_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset_o) |-> $past(fault_w && !cfg_mode));

endmodule

bind wwdt_top wwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .cfg_enable  (cfg_enable),
  .cfg_mode    (cfg_mode),
  .cfg_ceiling (cfg_ceiling),
  .count_w     (count_w),
  .reload_w    (reload_w),
  .refresh_w   (refresh_w),
  .fault_w     (fault_w),
  .raw_tmo     (raw_w.tmo),
  .wd_reset_o  (wd_reset_o)
);

// File: tb/wwdt_top_tb.sv
`timescale 1ns/1ps
module wwdt_top_tb;

  localparam logic [31:0] KEY = 32'hAC15DE42;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [25:0] cfg_load = '0;
  logic [31:0] cfg_ceiling = 32'd10;
  logic        cfg_enable = 1'b1;
  logic        cfg_mode = 1'b0;
  logic        sleep_i = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_reset_o, timeout_irq_o, wakeup_irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wwdt_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_load(cfg_load),
    .cfg_ceiling(cfg_ceiling), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .sleep_i(sleep_i), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_reset_o(wd_reset_o),
    .timeout_irq_o(timeout_irq_o), .wakeup_irq_o(wakeup_irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic do_reset(input logic [25:0] ld, input logic [31:0] ceil,
                          input logic en, input logic md);
    cfg_load = ld; cfg_ceiling = ceil; cfg_enable = en; cfg_mode = md;
    sleep_i = 1'b0; tick_en = 1'b0; bus_we = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    do_reset(26'd0, 32'd10, 1'b1, 1'b0);
    rd(3'd0, d); chk("R1 count after reset", d, 32'h3F);
    rd(3'd1, d); chk("R1 reload value", d, 32'h3F);
    rd(3'd2, d); chk("R1 ceiling readback", d, 32'd10);
    rd(3'd5, d); chk("R13 control reset", d, 32'h0);
    rd(3'd7, d); chk("R1 raw reset", d, 32'h0);
    chk("R1 outputs idle", {29'd0, wd_reset_o, timeout_irq_o, wakeup_irq_o}, 32'h0);
    cfg_load = 26'h1;
    rd(3'd1, d); chk("R1 reload low ones", d, 32'h7F);
  endtask

  task automatic t_decrement;
    logic [31:0] d;
    do_reset(26'd0, 32'd10, 1'b0, 1'b0);
    ticks(5);
    rd(3'd0, d); chk("R2 disabled holds", d, 32'h3F);
    cfg_enable = 1'b1;
    @(negedge clk);
    rd(3'd0, d); chk("R2 no tick holds", d, 32'h3F);
    ticks(7);
    rd(3'd0, d); chk("R2 seven ticks", d, 32'd56);
    rd(3'd4, d); chk("R13 enable bit", d, 32'h1);
  endtask

  task automatic t_key;
    logic [31:0] d;
    do_reset(26'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    ticks(10);
    wr(3'd3, KEY ^ 32'h1);
    rd(3'd0, d); chk("R3 wrong key ignored", d, 32'd53);
    wr(3'd2, KEY);
    rd(3'd0, d); chk("R3 key at wrong address ignored", d, 32'd53);
    rd(3'd3, d); chk("R3 key reg reads zero", d, 32'h0);
    wr(3'd3, KEY);
    rd(3'd0, d); chk("R6 refresh reloads", d, 32'h3F);
    chk("R6 no fault without window", {31'd0, wd_reset_o}, 32'h0);
  endtask

  task automatic t_window;
    logic [31:0] d;
    do_reset(26'd0, 32'd10, 1'b1, 1'b0);
    ticks(52);
    rd(3'd6, d); chk("R10 forbidden at 11", d, 32'h0);
    wr(3'd3, KEY);
    chk("R5 early refresh reset", {31'd0, wd_reset_o}, 32'h1);
    rd(3'd0, d); chk("R5 early refresh reloads", d, 32'h3F);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'd0, wd_reset_o}, 32'h0);
    rd(3'd7, d); chk("R8 raw untouched in mode 0", d, 32'h0);
    ticks(53);
    rd(3'd6, d); chk("R10 permitted at 10", d, 32'h1);
    wr(3'd3, KEY);
    chk("R4 permitted refresh no reset", {31'd0, wd_reset_o}, 32'h0);
    rd(3'd0, d); chk("R4 permitted refresh reloads", d, 32'h3F);
  endtask

  task automatic t_expiry_reset;
    logic [31:0] d;
    do_reset(26'd0, 32'd10, 1'b1, 1'b0);
    ticks(63);
    rd(3'd0, d); chk("R2 reached zero", d, 32'h0);
    chk("R7 no fault at zero yet", {31'd0, wd_reset_o}, 32'h0);
    ticks(1);
    chk("R7 expiry reset pulse", {31'd0, wd_reset_o}, 32'h1);
    rd(3'd0, d); chk("R7 expiry reloads", d, 32'h3F);
  endtask

  task automatic t_expiry_irq;
    logic [31:0] d;
    do_reset(26'd0, 32'd10, 1'b1, 1'b1);
    ticks(64);
    chk("R9 no reset in mode 1", {31'd0, wd_reset_o}, 32'h0);
    rd(3'd7, d); chk("R9 raw timeout set", d, 32'h1);
    chk("R9 irq masked", {31'd0, timeout_irq_o}, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R13 control bits", d, 32'h7);
    chk("R9 irq enabled", {31'd0, timeout_irq_o}, 32'h1);
    chk("R12 no wake when awake", {31'd0, wakeup_irq_o}, 32'h0);
    wr(3'd7, 32'h0);
    rd(3'd7, d); chk("R11 write zero no effect", d, 32'h1);
    wr(3'd7, 32'h1);
    rd(3'd7, d); chk("R11 write one clears", d, 32'h0);
    chk("R9 irq follows raw", {31'd0, timeout_irq_o}, 32'h0);
  endtask

  task automatic t_wakeup;
    logic [31:0] d;
    do_reset(26'd0, 32'd10, 1'b1, 1'b1);
    wr(3'd5, 32'h2);
    sleep_i = 1'b1;
    wr(3'd3, KEY);
    rd(3'd7, d); chk("R12 early refresh asleep sets both", d, 32'h3);
    chk("R12 wake irq", {31'd0, wakeup_irq_o}, 32'h1);
    chk("R9 timeout irq masked", {31'd0, timeout_irq_o}, 32'h0);
    wr(3'd7, 32'h2);
    rd(3'd7, d); chk("R11 clear wake only", d, 32'h1);
    rd(3'd5, d); chk("R13 mode bit reads 1", d, 32'h6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_decrement();
    t_key();
    t_window();
    t_expiry_reset();
    t_expiry_irq();
    t_wakeup();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule